// File: doc/BRIEF.md
# Program Control Instruction Executor

This block carries out three 16-bit control-flow instructions for a processor datapath. The three instructions are a priority-set instruction, an absolute jump and a decrement-and-loop branch. Each instruction is presented for one cycle with a `start` strobe. The surrounding datapath supplies the current processor mode and the content of the register named by the instruction. It also supplies the program counter, which already points past the instruction word, and the effective address that the operand logic has already resolved for the jump.

One cycle after `start`, the block returns its results as write strobes with data. These cover register write-back, the new program counter and the new three-bit priority field. In the same cycle the block raises either an illegal-instruction trap request or a boundary-error trap request. The enclosing core does the operand address calculation, the memory accesses and the trap sequencing.

The condition codes are never touched, so the block has no path to them. An instruction word that is none of the three completes with `done` alone.

Top module: `pcx_exec`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, every output is zero.
- R2: A word with bits 15..3 equal to 0000000010011 (octal 00023n) and `cur_mode` equal to 2'b00 (kernel) produces `prio_we`=1 and `prio_out`=instr[2:0], with no register or PC write and no trap.
- R3: The same priority-set word with `cur_mode` other than 2'b00 (2'b01 supervisor, 2'b11 user, 2'b10 reserved) has no effect: `prio_we`=0, with no other write and no trap.
- R4: A jump word (bits 15..6 equal to 0000000001, octal 0001dd) whose mode field instr[5:3] is 0 raises `trap_illegal` and does not write the PC.
- R5: A jump word with a nonzero mode field and an even `dest_addr` gives `pc_we`=1 and `pc_out`=`dest_addr`. This includes mode 1, register deferred, where `dest_addr` is the register's content.
- R6: A jump word with a nonzero mode field and an odd `dest_addr` raises `trap_odd` and does not write the PC.
- R7: A loop word (bits 15..9 equal to 0111111, octal 077roo) writes `reg_rdata` minus 1 modulo 2^16 to register instr[8:6]. When `reg_rdata` is 0 the written value is 16'hFFFF.
- R8: For a loop word whose decremented value is nonzero, `pc_we`=1 and `pc_out` = `pc_in` − 2·instr[5:0] modulo 2^16. The offset is unsigned, so the branch goes backward only.
- R9: For a loop word whose decremented value is zero, `pc_we`=1 and `pc_out`=`pc_in`, so execution falls through to the following word.
- R10: `done` pulses for exactly the cycle after each `start`, and every strobe and trap output is zero in cycles that do not follow a `start`. Any word that is not one of the three instructions yields `done` with no write and no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction present this cycle |
| instr | input | 16 | Instruction word |
| cur_mode | input | 2 | Processor mode: 00 kernel, 01 supervisor, 11 user |
| reg_rdata | input | 16 | Content of the register named by the instruction |
| pc_in | input | 16 | Program counter, pointing past the instruction |
| dest_addr | input | 16 | Resolved jump destination address |
| done | output | 1 | Completion pulse |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 3 | Register write index |
| reg_wdata | output | 16 | Register write data |
| pc_we | output | 1 | PC write strobe |
| pc_out | output | 16 | New PC value |
| prio_we | output | 1 | Priority field write strobe |
| prio_out | output | 3 | New priority value |
| trap_illegal | output | 1 | Illegal-instruction trap request |
| trap_odd | output | 1 | Boundary-error trap request |

## Verification
The bench builds the block with its default parameters: a 16-bit data path, a 6-bit loop offset and a 3-bit priority field. These widths make the wrap cases reachable with directed values. Examples are a loop register at 0 becoming 16'hFFFF and a PC near zero wrapping past the top of memory when the largest offset of 63 words is subtracted. With the 3-bit index and mode fields, the bench sweeps all eight jump modes and all eight loop registers, and tries the priority-set word in all four mode codes.

// File: rtl/pcx_pkg.sv
package pcx_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SETPRI = 2'd1,
        OP_JUMP = 2'd2,
        OP_LOOP = 2'd3
    } pcx_op_e;

    localparam logic [1:0] MODE_KERNEL = 2'b00;
endpackage

// File: rtl/pcx_decode.sv
module pcx_decode
    import pcx_pkg::*;
(
    input  logic [15:0] instr,
    output pcx_op_e     op
);
    localparam logic [12:0] SETPRI_HI = 13'b0000000010011;
    localparam logic [9:0]  JUMP_HI   = 10'b0000000001;
    localparam logic [6:0]  LOOP_HI   = 7'b0111111;

    always_comb begin
        op = OP_NONE;
        if (instr[15:3] == SETPRI_HI)
            op = OP_SETPRI;
        else if (instr[15:6] == JUMP_HI)
            op = OP_JUMP;
        else if (instr[15:9] == LOOP_HI)
            op = OP_LOOP;
    end
endmodule

// File: rtl/pcx_loop.sv
module pcx_loop #(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 6
) (
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] pc_val,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] dec_val,
    output logic              taken,
    output logic [DATA_W-1:0] target
);
    localparam int PAD_W = DATA_W - OFF_W - 1;

    logic [DATA_W-1:0] byte_off;

    always_comb begin
        dec_val  = reg_val - {{(DATA_W-1){1'b0}}, 1'b1};
        taken    = (dec_val != '0);
        byte_off = {{PAD_W{1'b0}}, offset, 1'b0};
        target   = pc_val - byte_off;
    end
endmodule

// File: rtl/pcx_exec.sv
module pcx_exec
    import pcx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OFF_W  = 6,
    parameter int PRIO_W = 3,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       instr,
    input  logic [1:0]        cur_mode,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [DATA_W-1:0] dest_addr,
    output logic              done,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              pc_we,
    output logic [DATA_W-1:0] pc_out,
    output logic              prio_we,
    output logic [PRIO_W-1:0] prio_out,
    output logic              trap_illegal,
    output logic              trap_odd
);
    localparam int MODE_LO = 3;
    localparam int RIDX_LO = 6;

    typedef struct packed {
        logic              done;
        logic              reg_we;
        logic [RIDX_W-1:0] reg_waddr;
        logic [DATA_W-1:0] reg_wdata;
        logic              pc_we;
        logic [DATA_W-1:0] pc_val;
        logic              prio_we;
        logic [PRIO_W-1:0] prio;
        logic              trap_ill;
        logic              trap_odd;
    } exec_s;

    exec_s   st_d, st_q;
    pcx_op_e op;

    logic [DATA_W-1:0] loop_dec;
    logic              loop_taken;
    logic [DATA_W-1:0] loop_target;

    pcx_decode u_dec (
        .instr (instr),
        .op    (op)
    );

    pcx_loop #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_loop (
        .reg_val (reg_rdata),
        .pc_val  (pc_in),
        .offset  (instr[OFF_W-1:0]),
        .dec_val (loop_dec),
        .taken   (loop_taken),
        .target  (loop_target)
    );

    always_comb begin
        st_d = '0;
        if (start) begin
            st_d.done = 1'b1;
            case (op)
                OP_SETPRI: begin
                    if (cur_mode == MODE_KERNEL) begin
                        st_d.prio_we = 1'b1;
                        st_d.prio    = instr[PRIO_W-1:0];
                    end
                end
                OP_JUMP: begin
                    if (instr[MODE_LO+2:MODE_LO] == 3'd0)
                        st_d.trap_ill = 1'b1;
                    else if (dest_addr[0])
                        st_d.trap_odd = 1'b1;
                    else begin
                        st_d.pc_we  = 1'b1;
                        st_d.pc_val = dest_addr;
                    end
                end
                OP_LOOP: begin
                    st_d.reg_we    = 1'b1;
                    st_d.reg_waddr = instr[RIDX_LO+RIDX_W-1:RIDX_LO];
                    st_d.reg_wdata = loop_dec;
                    st_d.pc_we     = 1'b1;
                    st_d.pc_val    = loop_taken ? loop_target : pc_in;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done         = st_q.done;
    assign reg_we       = st_q.reg_we;
    assign reg_waddr    = st_q.reg_waddr;
    assign reg_wdata    = st_q.reg_wdata;
    assign pc_we        = st_q.pc_we;
    assign pc_out       = st_q.pc_val;
    assign prio_we      = st_q.prio_we;
    assign prio_out     = st_q.prio;
    assign trap_illegal = st_q.trap_ill;
    assign trap_odd     = st_q.trap_odd;

    AST_PRIO_KERNEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        prio_we |-> ($past(cur_mode) == MODE_KERNEL)); // R3
    AST_ILLEGAL_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |-> (!pc_we && !trap_odd)); // R4
    AST_ODD_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        trap_odd |-> !pc_we); // R6
    AST_LOOP_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_wdata == '0) |-> (pc_we && pc_out == $past(pc_in))); // R9
    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        (done || pc_we || reg_we || prio_we) |-> $past(start)); // R10
    AST_PC_EVEN_ON_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && !reg_we) |-> !pc_out[0]); // R5
endmodule

// File: tb/pcx_exec_test.sv
`timescale 1ns/1ps
module pcx_exec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [1:0]  cur_mode = '0;
    logic [15:0] reg_rdata = '0;
    logic [15:0] pc_in = '0;
    logic [15:0] dest_addr = '0;
    logic        done, reg_we, pc_we, prio_we, trap_illegal, trap_odd;
    logic [2:0]  reg_waddr, prio_out;
    logic [15:0] reg_wdata, pc_out;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pcx_exec uut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .cur_mode(cur_mode), .reg_rdata(reg_rdata), .pc_in(pc_in),
        .dest_addr(dest_addr), .done(done), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .pc_we(pc_we),
        .pc_out(pc_out), .prio_we(prio_we), .prio_out(prio_out),
        .trap_illegal(trap_illegal), .trap_odd(trap_odd)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive one cycle (with or without start), then compare at the following negedge.
    task automatic step(input bit s, input logic [15:0] w, input logic [1:0] m,
                        input logic [15:0] rd, input logic [15:0] pc, input logic [15:0] da);
        int e_done, e_rwe, e_rwa, e_rwd, e_pwe, e_pc, e_prwe, e_pr, e_ill, e_odd, dec;
        string req, preq;
        start = s; instr = w; cur_mode = m; reg_rdata = rd; pc_in = pc; dest_addr = da;
        e_done = s; e_rwe = 0; e_rwa = 0; e_rwd = 0; e_pwe = 0; e_pc = 0;
        e_prwe = 0; e_pr = 0; e_ill = 0; e_odd = 0;
        req = "R10"; preq = "R10";
        if (s) begin
            if ((int'(w) >> 3) == 'o0023) begin
                if (m == 2'b00) begin e_prwe = 1; e_pr = int'(w) % 8; req = "R2"; end
                else req = "R3";
                preq = req;
            end else if ((int'(w) >> 6) == 'o0001) begin
                if (((int'(w) >> 3) % 8) == 0) begin e_ill = 1; req = "R4"; end
                else if (int'(da) % 2 == 1) begin e_odd = 1; req = "R6"; end
                else begin e_pwe = 1; e_pc = int'(da); req = "R5"; end
                preq = req;
            end else if ((int'(w) >> 9) == 'o077) begin
                dec = (int'(rd) + 65535) % 65536;
                e_rwe = 1; e_rwa = (int'(w) >> 6) % 8; e_rwd = dec; req = "R7";
                e_pwe = 1;
                if (dec != 0) begin
                    e_pc = (int'(pc) + 65536 - 2 * (int'(w) % 64)) % 65536; preq = "R8";
                end else begin
                    e_pc = int'(pc); preq = "R9";
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R10", "done", int'(done), e_done);
        chk(req, "reg_we", int'(reg_we), e_rwe);
        if (e_rwe != 0) begin
            chk(req, "reg_waddr", int'(reg_waddr), e_rwa);
            chk(req, "reg_wdata", int'(reg_wdata), e_rwd);
        end
        chk(preq, "pc_we", int'(pc_we), e_pwe);
        if (e_pwe != 0) chk(preq, "pc_out", int'(pc_out), e_pc);
        chk(req, "prio_we", int'(prio_we), e_prwe);
        if (e_prwe != 0) chk(req, "prio_out", int'(prio_out), e_pr);
        chk(req, "trap_illegal", int'(trap_illegal), e_ill);
        chk(req, "trap_odd", int'(trap_odd), e_odd);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: outputs zero during reset
        chk("R1", "outputs in reset",
            int'({done, reg_we, pc_we, prio_we, trap_illegal, trap_odd, pc_out, reg_wdata}), 0);
        rst_n = 1'b1;
        step(0, 16'h0, 2'b00, 16'h0, 16'h0, 16'h0); // R1: first cycle after reset

        // R2 / R3: priority set across all mode codes
        for (int m = 0; m < 4; m++)
            for (int n = 0; n < 8; n += 3)
                step(1, 16'o000230 | 16'(n), 2'(m), 16'h1234, 16'h0100, 16'h0202);
        step(1, 16'o000237, 2'b00, 16'h0, 16'h0, 16'h0);

        // R4 / R5 / R6: jump over every mode with even and odd destinations
        for (int md = 0; md < 8; md++) begin
            step(1, 16'o000100 | 16'(md * 8 + 3), 2'b11, 16'h0, 16'h0400, 16'h2000 + 16'(md * 2));
            step(1, 16'o000100 | 16'(md * 8 + 5), 2'b00, 16'h0, 16'h0400, 16'h3001 + 16'(md * 2));
        end
        step(1, 16'o000112, 2'b00, 16'h0, 16'h0, 16'hFFFE); // R5 register deferred, top even address

        // R7 / R8 / R9: loop branch
        for (int r = 0; r < 8; r++)
            step(1, 16'o077000 | 16'(r * 64 + r * 7), 2'b01, 16'(r + 5), 16'h1000, 16'h0);
        step(1, 16'o077277, 2'b00, 16'h0001, 16'h0500, 16'h0); // R9 reaches zero
        step(1, 16'o077300, 2'b00, 16'h0000, 16'h0500, 16'h0); // R7 wrap to FFFF, R8 offset 0
        step(1, 16'o077477, 2'b00, 16'h0003, 16'h0010, 16'h0); // R8 PC wraps below zero
        step(1, 16'o077101, 2'b00, 16'h0002, 16'h0002, 16'h0); // R8 target 0

        // R10: unrecognized words, idle cycles, back-to-back starts
        step(1, 16'o000240, 2'b00, 16'h0, 16'h0, 16'h0);
        step(1, 16'o000003, 2'b00, 16'h0, 16'h0, 16'h0);
        step(1, 16'o177777, 2'b00, 16'h0, 16'h0, 16'h0);
        step(1, 16'o076777, 2'b00, 16'h5, 16'h0, 16'h0);
        step(0, 16'o077201, 2'b00, 16'h5, 16'h100, 16'h0);
        step(0, 16'o000230, 2'b00, 16'h5, 16'h100, 16'h0);
        step(1, 16'o077201, 2'b10, 16'h9, 16'h100, 16'h0);
        step(1, 16'o000235, 2'b10, 16'h9, 16'h100, 16'h0);
        step(0, 16'h0, 2'b00, 16'h0, 16'h0, 16'h0);

        summary();
    end
endmodule